// File: doc/BRIEF.md
# Single-Cell End-of-Discharge Flag Monitor

This block watches a stream of digitized single-cell voltage readings and raises two sticky warnings as the cell runs empty. There are two programmable levels. The upper "early" level warns that the cell is nearly drained. The lower "last" level marks the point where the cell must be treated as empty. Each level drives its own flag. A flag sets as soon as a qualified reading drops below its level. It then holds, whatever later readings show, until the surrounding logic reports a valid charge.

Readings are ignored while the external overload indication is high, which means the discharge rate is above 2C. They stay ignored for a holdoff of a fixed number of one-second ticks after the overload goes away, so that the voltage sag under heavy load cannot trip a flag. The two levels are loaded through a small write port. Loading the early level also moves the last level to a fixed gap below it. The converter, the rate estimate and the charge qualification all live outside this block and reach it only as inputs.

Top module: `edv_flag_monitor`

## Requirements
- R1: After reset both flags read 0, the early level is 760 and the last level is 735 (millivolt codes), and readings are compared at once with no holdoff pending.
- R2: A reading with `smp_valid_i` high and `smp_mv_i` strictly below the early level sets `flag_early_o` on the next clock edge. A reading equal to the level does not set it.
- R3: A reading with `smp_valid_i` high and `smp_mv_i` strictly below the last level sets `flag_last_o` on the next clock edge.
- R4: A set flag stays set for any later reading, including readings above its level, until a charge clears it.
- R5: `chg_valid_i` high clears both flags on the next edge. If a below-level reading arrives in the same cycle, the clear takes priority and that reading is discarded.
- R6: While `ovld_i` is high, no reading sets either flag.
- R7: After `ovld_i` falls, readings are ignored until 12 cycles with `tick_1s_i` high have passed. A reading in the cycle after the 12th tick is compared. Overload rising again during the holdoff restarts the count.
- R8: A write with `cfg_sel_i`=0 loads the early level from `cfg_data_i` and sets the last level to that value minus 25, floored at 0. A write with `cfg_sel_i`=1 loads only the last level.
- R9: A reading with `smp_valid_i` low never sets a flag, whatever its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Level write strobe |
| cfg_sel_i | input | 1 | 0 = early level (last level follows), 1 = last level |
| cfg_data_i | input | 16 | Level value in mV |
| smp_valid_i | input | 1 | Reading qualifier |
| smp_mv_i | input | 16 | Single-cell reading in mV |
| ovld_i | input | 1 | Discharge rate above 2C |
| chg_valid_i | input | 1 | Valid charge event, clears flags |
| tick_1s_i | input | 1 | One pulse per second |
| flag_early_o | output | 1 | Sticky early-level flag |
| flag_last_o | output | 1 | Sticky last-level flag |

## Verification
The hardest case to reach is the exact edge of the overload holdoff. The holdoff state is not visible at the ports. The stimulus releases overload and then spends exactly eleven ticks and probes with a low reading, which must be ignored. One more tick follows, and the same probe must then set the flag. A second run re-arms overload halfway through the count, to show that the count restarts rather than resumes. A reference model in the bench tracks ticks since overload ended, and it is compared with both flags on every clock.

// File: rtl/edv_pkg.sv
package edv_pkg;
  localparam int unsigned MV_W = 16;
  typedef logic [MV_W-1:0] mv_t;
  typedef enum logic {
    SEL_EARLY = 1'b0,
    SEL_LAST  = 1'b1
  } lvl_sel_e;
  localparam int unsigned N_LVL = 2;
  localparam int unsigned IDX_EARLY = 0;
  localparam int unsigned IDX_LAST  = 1;
endpackage

// File: rtl/edv_rst_sync.sv
module edv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/edv_level_regs.sv
module edv_level_regs
  import edv_pkg::*;
#(
  parameter int unsigned DEF_EARLY_MV = 760,
  parameter int unsigned GAP_MV       = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic cfg_sel_i,
  input  mv_t  cfg_data_i,
  output mv_t  lvl_o [N_LVL]
);
  localparam mv_t DefEarly = mv_t'(DEF_EARLY_MV);
  localparam mv_t Gap      = mv_t'(GAP_MV);
  localparam mv_t DefLast  = (DefEarly > Gap) ? mv_t'(DefEarly - Gap) : '0;

  mv_t early_q, early_d, last_q, last_d;
  logic early_en, last_en;
  mv_t follow;

  always_comb begin
    follow   = (cfg_data_i > Gap) ? mv_t'(cfg_data_i - Gap) : '0;
    early_en = cfg_we_i && (lvl_sel_e'(cfg_sel_i) == SEL_EARLY);
    last_en  = cfg_we_i;
    early_d  = cfg_data_i;
    last_d   = (lvl_sel_e'(cfg_sel_i) == SEL_EARLY) ? follow : cfg_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_q <= DefEarly;
      last_q  <= DefLast;
    end else begin
      if (early_en) early_q <= early_d;
      if (last_en)  last_q  <= last_d;
    end
  end

  assign lvl_o[IDX_EARLY] = early_q;
  assign lvl_o[IDX_LAST]  = last_q;
endmodule

// File: rtl/edv_holdoff.sv
module edv_holdoff #(
  parameter int unsigned HOLD_SEC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovld_i,
  input  logic tick_i,
  output logic cmp_en_o
);
  localparam int unsigned CW = $clog2(HOLD_SEC + 1);
  localparam logic [CW-1:0] HoldLd = CW'(HOLD_SEC);

  logic [CW-1:0] left_q, left_d;
  logic          left_en;

  always_comb begin
    left_en = ovld_i || (tick_i && (left_q != '0));
    left_d  = ovld_i ? HoldLd : left_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign cmp_en_o = !ovld_i && (left_q == '0);
endmodule

// File: rtl/edv_flag_latch.sv
module edv_flag_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_en_i,
  input  logic below_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = clr_i || (cmp_en_i && below_i);
    flag_d  = !clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/edv_flag_monitor.sv
module edv_flag_monitor
  import edv_pkg::*;
#(
  parameter int unsigned DEF_EARLY_MV = 760,
  parameter int unsigned GAP_MV       = 25,
  parameter int unsigned HOLD_SEC     = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic        cfg_sel_i,
  input  logic [15:0] cfg_data_i,
  input  logic        smp_valid_i,
  input  logic [15:0] smp_mv_i,
  input  logic        ovld_i,
  input  logic        chg_valid_i,
  input  logic        tick_1s_i,
  output logic        flag_early_o,
  output logic        flag_last_o
);
  logic rst_n;
  logic hold_en;
  mv_t  lvl [N_LVL];
  logic [N_LVL-1:0] flag;

  edv_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i), .rst_ni (rst_ni), .rst_no (rst_n)
  );

  edv_level_regs #(.DEF_EARLY_MV(DEF_EARLY_MV), .GAP_MV(GAP_MV)) u_lvl (
    .clk_i (clk_i), .rst_ni (rst_n), .cfg_we_i (cfg_we_i),
    .cfg_sel_i (cfg_sel_i), .cfg_data_i (cfg_data_i), .lvl_o (lvl)
  );

  edv_holdoff #(.HOLD_SEC(HOLD_SEC)) u_hold (
    .clk_i (clk_i), .rst_ni (rst_n), .ovld_i (ovld_i),
    .tick_i (tick_1s_i), .cmp_en_o (hold_en)
  );

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    logic below;
    assign below = smp_mv_i < lvl[g];
    edv_flag_latch u_flag (
      .clk_i (clk_i), .rst_ni (rst_n),
      .cmp_en_i (hold_en && smp_valid_i), .below_i (below),
      .clr_i (chg_valid_i), .flag_o (flag[g])
    );
  end

  assign flag_early_o = flag[IDX_EARLY];
  assign flag_last_o  = flag[IDX_LAST];
endmodule

// File: rtl/edv_flag_monitor_chk.sv
module edv_flag_monitor_chk #(
  parameter int unsigned HOLD_SEC = 12
) (
  input logic clk_i,
  input logic rst_ni,
  input logic smp_valid_i,
  input logic ovld_i,
  input logic chg_valid_i,
  input logic tick_1s_i,
  input logic flag_early_o,
  input logic flag_last_o
);
  int unsigned since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             since_q <= HOLD_SEC;
    else if (ovld_i)                         since_q <= 0;
    else if (tick_1s_i && since_q < HOLD_SEC) since_q <= since_q + 1;
  end

  a_r4_early_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_early_o && !chg_valid_i) |=> flag_early_o);
  a_r4_last_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_last_o && !chg_valid_i) |=> flag_last_o);
  a_r5_charge_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_valid_i |=> (!flag_early_o && !flag_last_o));
  a_r6_ovld_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovld_i && !flag_early_o && !flag_last_o) |=> (!flag_early_o && !flag_last_o));
  a_r7_holdoff_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q < HOLD_SEC && !flag_early_o && !flag_last_o) |=> (!flag_early_o && !flag_last_o));
  a_r9_invalid_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !flag_early_o && !flag_last_o) |=> (!flag_early_o && !flag_last_o));
endmodule

bind edv_flag_monitor edv_flag_monitor_chk #(.HOLD_SEC(HOLD_SEC)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_n), .smp_valid_i (smp_valid_i),
  .ovld_i (ovld_i), .chg_valid_i (chg_valid_i), .tick_1s_i (tick_1s_i),
  .flag_early_o (flag_early_o), .flag_last_o (flag_last_o)
);

// File: tb/tb_edv_flag_monitor.sv
module tb_edv_flag_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_data = '0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_mv = '0;
  logic        ovld = 1'b0, chg = 1'b0, tick = 1'b0;
  logic        f_early, f_last;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  int m_early = 760, m_last = 735, m_since = 12;
  bit m_fe = 0, m_fl = 0, model_on = 0;

  always #4 clk = ~clk;

  edv_flag_monitor dut (
    .clk_i (clk), .rst_ni (rst_n), .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel),
    .cfg_data_i (cfg_data), .smp_valid_i (smp_valid), .smp_mv_i (smp_mv),
    .ovld_i (ovld), .chg_valid_i (chg), .tick_1s_i (tick),
    .flag_early_o (f_early), .flag_last_o (f_last)
  );

  always @(posedge clk) begin
    if (model_on) begin
      bit en;
      en = !ovld && m_since >= 12;
      if (chg) begin
        m_fe = 0; m_fl = 0;
      end else if (en && smp_valid) begin
        if (int'(smp_mv) < m_early) m_fe = 1;
        if (int'(smp_mv) < m_last)  m_fl = 1;
      end
      if (ovld) m_since = 0;
      else if (tick && m_since < 12) m_since++;
      if (cfg_we) begin
        if (!cfg_sel) begin
          m_early = int'(cfg_data);
          m_last  = (int'(cfg_data) > 25) ? int'(cfg_data) - 25 : 0;
        end else m_last = int'(cfg_data);
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      total++;
      if (f_early !== m_fe || f_last !== m_last_flag()) begin
        bad++;
        $display("FAIL model R2/R3 per-cycle: actual=%b%b expected=%b%b", f_early, f_last, m_fe, m_fl);
      end
    end
  end

  function automatic bit m_last_flag();
    return m_fl;
  endfunction

  task automatic chk(input string req, input bit act_e, input bit act_l, input bit exp_e, input bit exp_l);
    total++;
    if (act_e !== exp_e || act_l !== exp_l) begin
      bad++;
      $display("FAIL %s: actual early=%b last=%b expected early=%b last=%b", req, act_e, act_l, exp_e, exp_l);
    end
  endtask

  task automatic cyc(input bit v, input int mv, input bit ov, input bit c, input bit t);
    smp_valid = v; smp_mv = 16'(mv); ovld = ov; chg = c; tick = t;
    @(negedge clk);
    smp_valid = 0; ovld = 0; chg = 0; tick = 0;
  endtask

  task automatic wr(input bit sel, input int val);
    cfg_we = 1; cfg_sel = sel; cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        model_on = 1;
        chk("R1 reset flags", f_early, f_last, 0, 0);
        cyc(1, 760, 0, 0, 0); chk("R1 default early, R2 equal no set", f_early, f_last, 0, 0);
        cyc(1, 759, 0, 0, 0); chk("R2 below early", f_early, f_last, 1, 0);
        cyc(1, 800, 0, 0, 0); chk("R4 sticky above level", f_early, f_last, 1, 0);
        cyc(0, 100, 0, 0, 0); chk("R9 invalid ignored", f_early, f_last, 1, 0);
        cyc(1, 735, 0, 0, 0); chk("R1 default last equal", f_early, f_last, 1, 0);
        cyc(1, 734, 0, 0, 0); chk("R3 below last", f_early, f_last, 1, 1);
        cyc(1, 700, 0, 1, 0); chk("R5 charge wins", f_early, f_last, 0, 0);
        cyc(1, 700, 1, 0, 1); chk("R6 overload blocks", f_early, f_last, 0, 0);
        for (int i = 0; i < 11; i++) cyc(0, 0, 0, 0, 1);
        cyc(1, 700, 0, 0, 0); chk("R7 holdoff after 11 ticks", f_early, f_last, 0, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 700, 0, 0, 0); chk("R7 resume after 12 ticks", f_early, f_last, 1, 1);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1);
        cyc(1, 700, 0, 0, 0); chk("R7 restart on new overload", f_early, f_last, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1);
        cyc(1, 740, 0, 0, 0); chk("R7 resume after restart", f_early, f_last, 1, 0);
        cyc(0, 0, 0, 1, 0);
        wr(0, 800);
        cyc(1, 790, 0, 0, 0); chk("R8 early reload", f_early, f_last, 1, 0);
        cyc(1, 775, 0, 0, 0); chk("R8 last follows equal", f_early, f_last, 1, 0);
        cyc(1, 774, 0, 0, 0); chk("R8 last follows below", f_early, f_last, 1, 1);
        cyc(0, 0, 0, 1, 0);
        wr(1, 700);
        cyc(1, 720, 0, 0, 0); chk("R8 explicit last write", f_early, f_last, 1, 0);
        cyc(1, 699, 0, 0, 0); chk("R8 explicit last below", f_early, f_last, 1, 1);
        cyc(0, 0, 0, 1, 0);
        wr(0, 10);
        cyc(1, 0, 0, 0, 0); chk("R8 last floored at zero", f_early, f_last, 1, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R5 clear", f_early, f_last, 0, 0);
        done = 1;
      end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: actual=timeout expected=completion");
          done = 1;
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule